// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit resolves the operand of a load-to-accumulator operation. It takes a 4-bit mode code and an address field from a decoded instruction. From these it forms the effective address (EA) and, when the mode needs one, reads the operand from a synchronous memory port. It then raises a one-cycle done strobe with the EA and the operand on its outputs.

The unit holds four address registers: the program counter, a general register R1, an index register and a base register. A small load port writes them. Indirect mode makes two reads: first a pointer, then the operand. The two auto modes step R1, one before the EA is formed and the other after. PC-relative mode adds the field to the PC as it stands once a two-word instruction has been passed.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `mode_err` and `mem_re` are 0. `ea` and `operand` are 0. The PC, R1, index and base registers all hold 0.
- R2: The mode codes are: 0 implied, 1 immediate, 2 register, 3 register indirect, 4 autoincrement, 5 autodecrement, 6 direct, 7 indirect, 8 PC-relative, 9 indexed, 10 base. Codes 0, 1 and 2 make no memory read and pulse `done` one cycle after `start` is sampled, with `ea` = 0. The operand is 0 for implied, the address field for immediate and R1 for register.
- R3: For direct (EA = field) and register indirect (EA = R1), one read of M[EA] is issued. `done` rises 3 cycles after `start` is sampled, with `operand` = M[EA].
- R4: Indirect mode reads M[field] as a pointer and then reads M[pointer]. It reports EA = pointer, uses two reads and raises `done` 5 cycles after `start`.
- R5: PC-relative EA = PC + 2 + field. The PC advances by 2 at every completion.
- R6: Indexed EA = XR + field. Base EA = BAR + field. Each makes one read with the same 3-cycle timing.
- R7: Autoincrement uses the present R1 as the EA, then R1 becomes R1 + 1.
- R8: Autodecrement sets R1 to R1 − 1 first and uses that new value as the EA.
- R9: All EA and register arithmetic wraps modulo 2^W.
- R10: Codes 11 to 15 pulse `done` together with `mode_err` after one cycle, with `ea` = `operand` = 0, no read, and R1 unchanged.
- R11: A `start` while an operation is in flight is ignored. It causes no extra read and no extra `done`.
- R12: The load port (`reg_sel` 0 = PC, 1 = R1, 2 = XR, 3 = BAR) beats a same-edge PC advance or R1 step. The EA of an operation accepted on that edge uses the register values from before the edge.
- R13: `done` is a single-cycle pulse per operation. `ea` and `operand` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 4 | Addressing mode code |
| addr_field | input | W | Address field of the instruction |
| reg_we | input | 1 | Load strobe for an address register |
| reg_sel | input | 2 | Register chosen for loading |
| reg_wdata | input | W | Value to load |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | W | Memory read address |
| mem_rdata | input | W | Read data, valid one cycle after the request |
| ea | output | W | Effective address |
| operand | output | W | Fetched or formed operand |
| done | output | 1 | Operation complete |
| mode_err | output | 1 | Unused mode code, pulses with done |

## Verification
Two things can hit R1 on the same edge: a load through the register port and the step made by an auto mode. The PC advance and a PC load can collide in the same way. The bench provokes the collision by raising `start` with autoincrement in the same cycle as a load of R1. It then checks that the EA of that operation is the old R1, and that a later register-mode operation returns the loaded value rather than the stepped one. A load of XR made alongside an indexed `start` is judged the same way: the first EA uses the old XR and the next uses the new one.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   mode,
  input  logic [W-1:0] addr_field,
  input  logic         reg_we,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] ea,
  output logic [W-1:0] operand,
  output logic         done,
  output logic         mode_err
);

  localparam logic [3:0] M_IMPL = 4'd0, M_IMM = 4'd1, M_REG = 4'd2, M_RIND = 4'd3,
                         M_AINC = 4'd4, M_ADEC = 4'd5, M_DIR = 4'd6, M_IND = 4'd7,
                         M_PCR  = 4'd8, M_IDX = 4'd9, M_BASE = 4'd10;

  typedef enum logic [2:0] {S_IDLE, S_PTR, S_PTR_DATA, S_OP, S_OP_DATA} state_t;

  state_t state;
  logic [W-1:0] pc_q, r1_q, xr_q, bar_q;
  logic [W-1:0] ea_q, op_q, addr_q;
  logic         re_q, done_q, err_q;

  logic [W-1:0] ea_c;
  logic         one_read, is_ind, is_bad;
  logic         idle, accept, finish;

  assign idle   = (state == S_IDLE);
  assign accept = start && idle;

  always_comb begin
    ea_c     = '0;
    one_read = 1'b1;
    case (mode)
      M_RIND, M_AINC: ea_c = r1_q;
      M_ADEC:         ea_c = r1_q - W'(1);
      M_DIR:          ea_c = addr_field;
      M_PCR:          ea_c = pc_q + W'(2) + addr_field;
      M_IDX:          ea_c = xr_q + addr_field;
      M_BASE:         ea_c = bar_q + addr_field;
      default:        one_read = 1'b0;
    endcase
  end

  assign is_ind = (mode == M_IND);
  assign is_bad = (mode > M_BASE);
  assign finish = (state == S_OP_DATA) || (accept && !one_read && !is_ind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ea_q   <= '0;
      op_q   <= '0;
      addr_q <= '0;
      re_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      re_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (one_read) begin
            ea_q   <= ea_c;
            addr_q <= ea_c;
            re_q   <= 1'b1;
            state  <= S_OP;
          end else if (is_ind) begin
            addr_q <= addr_field;
            re_q   <= 1'b1;
            state  <= S_PTR;
          end else begin
            ea_q   <= '0;
            op_q   <= (mode == M_IMM) ? addr_field :
                      (mode == M_REG) ? r1_q : '0;
            err_q  <= is_bad;
            done_q <= 1'b1;
          end
        end
        S_PTR:      state <= S_PTR_DATA;
        S_PTR_DATA: begin
          ea_q   <= mem_rdata;
          addr_q <= mem_rdata;
          re_q   <= 1'b1;
          state  <= S_OP;
        end
        S_OP:       state <= S_OP_DATA;
        S_OP_DATA: begin
          op_q   <= mem_rdata;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default:    state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      r1_q  <= '0;
      xr_q  <= '0;
      bar_q <= '0;
    end else begin
      if (reg_we && reg_sel == 2'd0) pc_q <= reg_wdata;
      else if (finish)               pc_q <= pc_q + W'(2);

      if (reg_we && reg_sel == 2'd1)     r1_q <= reg_wdata;
      else if (accept && mode == M_AINC) r1_q <= r1_q + W'(1);
      else if (accept && mode == M_ADEC) r1_q <= r1_q - W'(1);

      if (reg_we && reg_sel == 2'd2) xr_q  <= reg_wdata;
      if (reg_we && reg_sel == 2'd3) bar_q <= reg_wdata;
    end
  end

  assign mem_re   = re_q;
  assign mem_addr = addr_q;
  assign ea       = ea_q;
  assign operand  = op_q;
  assign done     = done_q;
  assign mode_err = err_q;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         idle,
  input logic [3:0]   mode,
  input logic         reg_we,
  input logic [1:0]   reg_sel,
  input logic [W-1:0] reg_wdata,
  input logic         done,
  input logic         mode_err,
  input logic         mem_re,
  input logic [W-1:0] operand,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] r1_q
);

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (done && !mem_re));

  // R7
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && mode == 4'd4 && !(reg_we && reg_sel == 2'd1))
      |=> r1_q == $past(r1_q) + W'(1));

  // R8
  autodec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && mode == 4'd5 && !(reg_we && reg_sel == 2'd1))
      |=> r1_q == $past(r1_q) - W'(1));

  // R12
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1) |=> r1_q == $past(reg_wdata));

  // R5
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(reg_we && reg_sel == 2'd0)) |-> pc_q == $past(pc_q) + W'(2));

  // R13
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(operand));

endmodule

bind ea_unit ea_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .mode(mode),
  .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .done(done), .mode_err(mode_err), .mem_re(mem_re), .operand(operand),
  .pc_q(pc_q), .r1_q(r1_q)
);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   mode = '0;
  logic [W-1:0] addr_field = '0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_sel = '0;
  logic [W-1:0] reg_wdata = '0;
  logic         mem_re;
  logic [W-1:0] mem_addr;
  logic [W-1:0] mem_rdata = '0;
  logic [W-1:0] ea, operand;
  logic         done, mode_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ea_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_field(addr_field),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ea(ea), .operand(operand), .done(done), .mode_err(mode_err)
  );

  function automatic logic [W-1:0] mem_fn(input logic [W-1:0] a);
    case (a)
      16'd500: return 16'd800;
      16'd800: return 16'd300;
      16'd702: return 16'd325;
      16'd600: return 16'd900;
      16'd400: return 16'd700;
      16'd399: return 16'd450;
      default: return a ^ 16'h5A5A;
    endcase
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= mem_fn(mem_addr);

  // {mode, field, ea, operand, latency, reads, err}
  localparam logic [58:0] VEC [16] = '{
    {4'd8,  16'd500, 16'd702,  16'd325, 4'd3, 2'd1, 1'b0},
    {4'd6,  16'd500, 16'd500,  16'd800, 4'd3, 2'd1, 1'b0},
    {4'd1,  16'd500, 16'd0,    16'd500, 4'd1, 2'd0, 1'b0},
    {4'd7,  16'd500, 16'd800,  16'd300, 4'd5, 2'd2, 1'b0},
    {4'd9,  16'd500, 16'd600,  16'd900, 4'd3, 2'd1, 1'b0},
    {4'd2,  16'd0,   16'd0,    16'd400, 4'd1, 2'd0, 1'b0},
    {4'd3,  16'd0,   16'd400,  16'd700, 4'd3, 2'd1, 1'b0},
    {4'd5,  16'd0,   16'd399,  16'd450, 4'd3, 2'd1, 1'b0},
    {4'd4,  16'd0,   16'd399,  16'd450, 4'd3, 2'd1, 1'b0},
    {4'd3,  16'd0,   16'd400,  16'd700, 4'd3, 2'd1, 1'b0},
    {4'd4,  16'd0,   16'd400,  16'd700, 4'd3, 2'd1, 1'b0},
    {4'd2,  16'd0,   16'd0,    16'd401, 4'd1, 2'd0, 1'b0},
    {4'd10, 16'd500, 16'd1500, 16'h05DC ^ 16'h5A5A, 4'd3, 2'd1, 1'b0},
    {4'd0,  16'd123, 16'd0,    16'd0,   4'd1, 2'd0, 1'b0},
    {4'd11, 16'd500, 16'd0,    16'd0,   4'd1, 2'd0, 1'b1},
    {4'd15, 16'd500, 16'd0,    16'd0,   4'd1, 2'd0, 1'b1}
  };

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1, 4'd2: return "R2";
      4'd3, 4'd6:       return "R3";
      4'd7:             return "R4";
      4'd8:             return "R5";
      4'd9, 4'd10:      return "R6";
      4'd4:             return "R7";
      4'd5:             return "R8";
      default:          return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic load_reg(input logic [1:0] sel, input logic [W-1:0] val);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  logic [W-1:0] got_ea, got_op;
  logic         got_err;
  int           lat, reads;

  task automatic run_op(input logic [3:0] m, input logic [W-1:0] f);
    start = 1'b1; mode = m; addr_field = f;
    lat = 0; reads = 0;
    @(negedge clk);
    start = 1'b0; reg_we = 1'b0;
    lat = 1;
    if (mem_re) reads++;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      if (mem_re) reads++;
    end
    got_ea = ea; got_op = operand; got_err = mode_err;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "done", done, 0);
    chk("R1", "mem_re", mem_re, 0);
    chk("R1", "ea", ea, 0);
    chk("R1", "operand", operand, 0);
    chk("R1", "mode_err", mode_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(4'd2, 16'd0);
    chk("R1", "R1 after reset", got_op, 0);

    load_reg(2'd0, 16'd200);
    load_reg(2'd1, 16'd400);
    load_reg(2'd2, 16'd100);
    load_reg(2'd3, 16'd1000);

    for (int i = 0; i < 16; i++) begin
      logic [58:0] v;
      string t;
      v = VEC[i];
      t = req_of(v[58:55]);
      run_op(v[58:55], v[54:39]);
      chk(t, "ea", got_ea, v[38:23]);
      chk(t, "operand", got_op, v[22:7]);
      chk(t, "latency", lat, v[6:3]);
      chk(t, "reads", reads, v[2:1]);
      chk(t, "mode_err", got_err, v[0]);
    end

    // R10 error code leaves R1 unchanged (401)
    run_op(4'd13, 16'd7);
    chk("R10", "err", got_err, 1);
    run_op(4'd2, 16'd0);
    chk("R10", "R1 kept", got_op, 16'd401);

    // R5 PC advance by 2 per completion
    load_reg(2'd0, 16'd200);
    run_op(4'd0, 16'd0);
    run_op(4'd8, 16'd0);
    chk("R5", "ea after advance", got_ea, 16'd204);
    chk("R5", "operand", got_op, 16'd204 ^ 16'h5A5A);

    // R9 wrap
    run_op(4'd9, 16'hFFFF);
    chk("R9", "indexed wrap ea", got_ea, 16'd99);
    load_reg(2'd1, 16'd0);
    run_op(4'd5, 16'd0);
    chk("R9", "autodec wrap ea", got_ea, 16'hFFFF);
    chk("R9", "autodec wrap op", got_op, 16'hA5A5);
    run_op(4'd2, 16'd0);
    chk("R9", "R1 wrapped", got_op, 16'hFFFF);

    // R12 same-edge load vs autoincrement step
    load_reg(2'd1, 16'd20);
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 16'd50;
    run_op(4'd4, 16'd0);
    chk("R12", "ea uses old R1", got_ea, 16'd20);
    run_op(4'd2, 16'd0);
    chk("R12", "load wins over step", got_op, 16'd50);
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 16'd7;
    run_op(4'd9, 16'd0);
    chk("R12", "ea uses old XR", got_ea, 16'd100);
    run_op(4'd9, 16'd0);
    chk("R12", "ea uses new XR", got_ea, 16'd7);

    // R11 start while busy is ignored
    begin
      int extra_done, extra_reads;
      start = 1'b1; mode = 4'd7; addr_field = 16'd500;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; mode = 4'd6; addr_field = 16'd600;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk("R11", "ea", ea, 16'd800);
      chk("R11", "operand", operand, 16'd300);
      extra_done = 0; extra_reads = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) extra_done++;
        if (mem_re) extra_reads++;
      end
      chk("R11", "extra done", extra_done, 0);
      chk("R11", "extra reads", extra_reads, 0);
      // R13 outputs hold between completions
      chk("R13", "operand held", operand, 16'd300);
      chk("R13", "ea held", ea, 16'd800);
    end

    // R13 done is a single-cycle pulse
    run_op(4'd6, 16'd500);
    @(negedge clk);
    chk("R13", "done cleared", done, 0);
    chk("R13", "operand held", operand, 16'd800);

    report();
  end

endmodule